// File: doc/BRIEF.md
# Multiprocessor Prioritizing Interrupt Controller

This block collects fifteen interrupt request lines, numbered 1 to 15, and delivers interrupts to up to sixteen processors. Every processor sees the same shared pending bits. It also has a private mask and a private set of force bits. Each processor receives a registered 4-bit interrupt number, which is the most urgent request it is allowed to take. The processor answers with an acknowledge strobe that carries the number it took.

A shared level register divides the lines into two priority tiers. A shared broadcast register lets a request reach every processor at once through the force bits. A status word reports the number of processors and which processors are halted. Writing ones to that word starts halted processors. Software reaches all registers through a simple 32-bit read/write port that decodes a 256-byte window by word address.

Top module: `mpic_ctrl`

## Requirements
- R1: For each processor c, the candidate vector is (pending | force[c]) & mask[c]. A processor whose candidate vector is zero gets interrupt number 0.
- R2: A candidate whose bit is set in the level register beats every candidate whose bit is clear. Within one tier the highest number wins. The output appears one clock after the registers change.
- R3: Bit 0 of every 16-bit register (level at word 0x00, mask, force, pending, broadcast) ignores writes and always reads 0. For example, writing 0xFFFF to level reads back 0xFFFE.
- R4: A rising edge on request line n sets force[c] bit n in every processor when more than one processor exists and broadcast bit n is 1. Otherwise it sets shared pending bit n. A line that stays high causes only one set.
- R5: An acknowledge of number n by processor c clears force[c] bit n when that bit is set and leaves pending unchanged. Otherwise it clears pending bit n.
- R6: The status word at offset 0x10 reads as follows: bits 31:28 hold the processor count minus 1; bit 27 is 1 when more than one processor exists; bits 19:16 are 0; bit i is 1 while processor i is halted.
- R7: Writing the status word with bit i set releases processor i. Bits written as 0 leave the halted state unchanged.
- R8: A pulse on the power-down input of processor i marks it halted. A nonzero interrupt output to processor i releases it one clock later.
- R9: Writing ones to the clear word at offset 0x0C clears the matching pending bits. The clear word always reads 0.
- R10: Reset zeroes level, pending, broadcast, every mask and every force register, and marks every processor except processor 0 as halted.
- R11: The pending bits are at offset 0x04 and the broadcast bits at 0x14. The mask of processor i is at 0x40+4i, and its force bits are at 0x80+4i. Offset 0x08 is an alias of the force bits of processor 0. Offsets of absent processors, and the block at 0xC0, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_word | input | 6 | Word address (byte offset bits 7:2) |
| bus_wdata | input | 16 | Write data (registers are 16 bits wide) |
| bus_rdata | output | 32 | Read data for bus_word, combinational |
| irq_in | input | 16 | Request lines; bit 0 unused |
| ack_vld | input | NCPU | Per-processor acknowledge strobe |
| ack_num | input | 4*NCPU | Acknowledged number, 4 bits per processor |
| pwr_down | input | NCPU | Per-processor power-down pulse |
| cpu_irq | output | 4*NCPU | Registered interrupt number, 4 bits per processor |

## Verification
The assertions assume that the acknowledge number of a processor is stable for the cycle in which its strobe is high. They also assume that the write strobe is a clean single-cycle pulse, so that a bus write and an acknowledge of the same force bit in the same cycle never need to be told apart. The bench drives every input just after the falling clock edge and never overlaps a register write with an acknowledge or a request edge. Request lines are pulsed or held only at chosen points, so each edge has one intended effect on pending or force.

// File: rtl/mpic_pkg.sv
package mpic_pkg;

    localparam int VEC_W = 16;
    localparam int NUM_W = 4;
    localparam logic [VEC_W-1:0] LINE_MASK = 16'hFFFE;

    typedef logic [VEC_W-1:0] vec_t;
    typedef logic [NUM_W-1:0] num_t;

    typedef enum logic [3:0] {
        G_LEVEL  = 4'd0,
        G_PEND   = 4'd1,
        G_FORCE0 = 4'd2,
        G_CLEAR  = 4'd3,
        G_STATUS = 4'd4,
        G_BCAST  = 4'd5
    } greg_e;

    typedef struct packed {
        logic glb;
        logic msk;
        logic frc;
        logic [3:0] idx;
    } dec_t;

    function automatic num_t pick_top(vec_t v);
        num_t r;
        r = '0;
        for (int i = 1; i < VEC_W; i++) begin
            if (v[i]) r = num_t'(i);
        end
        return r;
    endfunction

    function automatic dec_t decode(logic [5:0] w);
        dec_t d;
        d.glb = (w[5:4] == 2'b00);
        d.msk = (w[5:4] == 2'b01);
        d.frc = (w[5:4] == 2'b10);
        d.idx = w[3:0];
        return d;
    endfunction

endpackage

// File: rtl/mpic_edge.sv
module mpic_edge
    import mpic_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  vec_t lines,
    output vec_t rise
);
    vec_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lines;
    end

    assign rise = lines & ~prev_q & LINE_MASK;
endmodule

// File: rtl/mpic_prio.sv
module mpic_prio
    import mpic_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  vec_t pend,
    input  vec_t frc,
    input  vec_t mask,
    input  vec_t lvl,
    output num_t irq_o
);
    vec_t cand;
    num_t hi_num;
    num_t lo_num;
    num_t sel_num;

    always_comb begin
        cand    = (pend | frc) & mask;
        hi_num  = pick_top(cand & lvl);
        lo_num  = pick_top(cand & ~lvl);
        sel_num = (hi_num != '0) ? hi_num : lo_num;
    end

    always_ff @(posedge clk) begin
        if (rst) irq_o <= '0;
        else     irq_o <= sel_num;
    end

    AST_OUT_NONZERO: assert property (@(posedge clk) disable iff (rst)
        ((cand & LINE_MASK) != '0) |=> (irq_o != '0)); // R1
    AST_OUT_ZERO: assert property (@(posedge clk) disable iff (rst)
        ((cand & LINE_MASK) == '0) |=> (irq_o == '0)); // R1
endmodule

// File: rtl/mpic_ctrl.sv
module mpic_ctrl
    import mpic_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [5:0]        bus_word,
    input  logic [15:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [15:0]       irq_in,
    input  logic [NCPU-1:0]   ack_vld,
    input  logic [NCPU*4-1:0] ack_num,
    input  logic [NCPU-1:0]   pwr_down,
    output logic [NCPU*4-1:0] cpu_irq
);
    localparam logic MULTI = (NCPU > 1);
    localparam logic [NCPU-1:0] HALT_RST = ~(NCPU'(1));
    localparam logic [3:0] CNT_M1 = 4'(NCPU - 1);

    vec_t lvl_q, pend_q, bc_q;
    vec_t lvl_n, pend_n, bc_n;
    vec_t [NCPU-1:0] mask_q, frc_q, mask_n, frc_n;
    logic [NCPU-1:0] halt_q, halt_n, wake_wr, irq_nz;
    vec_t rise;
    vec_t pend_clr;
    dec_t dec;
    logic wr_en;

    assign dec   = decode(bus_word);
    assign wr_en = bus_sel && bus_wr;

    mpic_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .lines (irq_in),
        .rise  (rise)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        num_t out_c;
        mpic_prio u_prio (
            .clk   (clk),
            .rst   (rst),
            .pend  (pend_q),
            .frc   (frc_q[c]),
            .mask  (mask_q[c]),
            .lvl   (lvl_q),
            .irq_o (out_c)
        );
        assign cpu_irq[c*4 +: 4] = out_c;
        assign irq_nz[c] = (out_c != '0);

        num_t an;
        assign an = ack_num[c*4 +: 4];

        AST_ACK_FORCE: assert property (@(posedge clk) disable iff (rst)
            (ack_vld[c] && frc_q[c][an] && !wr_en && !rise[an])
            |=> !frc_q[c][$past(an)]); // R5
        AST_WAKE_OUT: assert property (@(posedge clk) disable iff (rst)
            irq_nz[c] |=> !halt_q[c]); // R8
        AST_WAKE_WR: assert property (@(posedge clk) disable iff (rst)
            (wr_en && dec.glb && dec.idx == 4'(G_STATUS) && bus_wdata[c])
            |=> !halt_q[c]); // R7
    end

    for (genvar n = 1; n < VEC_W; n++) begin : g_line
        AST_PEND_SET: assert property (@(posedge clk) disable iff (rst)
            (rise[n] && !(MULTI && bc_q[n])) |=> pend_q[n]); // R4
    end

    always_comb begin
        lvl_n    = lvl_q;
        pend_n   = pend_q;
        bc_n     = bc_q;
        mask_n   = mask_q;
        frc_n    = frc_q;
        wake_wr  = '0;
        pend_clr = '0;

        if (wr_en) begin
            if (dec.glb) begin
                case (dec.idx)
                    4'(G_LEVEL):  lvl_n     = bus_wdata & LINE_MASK;
                    4'(G_PEND):   pend_n    = bus_wdata & LINE_MASK;
                    4'(G_FORCE0): frc_n[0]  = bus_wdata & LINE_MASK;
                    4'(G_CLEAR):  pend_n    = pend_q & ~bus_wdata;
                    4'(G_STATUS): wake_wr   = bus_wdata[NCPU-1:0];
                    4'(G_BCAST):  bc_n      = bus_wdata & LINE_MASK;
                    default: ;
                endcase
            end else begin
                for (int c = 0; c < NCPU; c++) begin
                    if (int'(dec.idx) == c) begin
                        if (dec.msk) mask_n[c] = bus_wdata & LINE_MASK;
                        if (dec.frc) frc_n[c]  = bus_wdata & LINE_MASK;
                    end
                end
            end
        end

        for (int c = 0; c < NCPU; c++) begin
            if (ack_vld[c]) begin
                if (frc_q[c][ack_num[c*4 +: 4]])
                    frc_n[c][ack_num[c*4 +: 4]] = 1'b0;
                else
                    pend_clr[ack_num[c*4 +: 4]] = 1'b1;
            end
        end
        pend_n = pend_n & ~pend_clr;

        for (int n = 1; n < VEC_W; n++) begin
            if (rise[n]) begin
                if (MULTI && bc_q[n]) begin
                    for (int c = 0; c < NCPU; c++) frc_n[c][n] = 1'b1;
                end else begin
                    pend_n[n] = 1'b1;
                end
            end
        end

        halt_n = (halt_q | pwr_down) & ~(wake_wr | irq_nz);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= '0;
            pend_q <= '0;
            bc_q   <= '0;
            mask_q <= '0;
            frc_q  <= '0;
            halt_q <= HALT_RST;
        end else begin
            lvl_q  <= lvl_n;
            pend_q <= pend_n;
            bc_q   <= bc_n;
            mask_q <= mask_n;
            frc_q  <= frc_n;
            halt_q <= halt_n;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (dec.glb) begin
            case (dec.idx)
                4'(G_LEVEL):  bus_rdata = {16'h0, lvl_q};
                4'(G_PEND):   bus_rdata = {16'h0, pend_q};
                4'(G_FORCE0): bus_rdata = {16'h0, frc_q[0]};
                4'(G_STATUS): bus_rdata = {CNT_M1, MULTI, 11'h0, 16'(halt_q)};
                4'(G_BCAST):  bus_rdata = {16'h0, bc_q};
                default:      bus_rdata = '0;
            endcase
        end else begin
            for (int c = 0; c < NCPU; c++) begin
                if (int'(dec.idx) == c) begin
                    if (dec.msk) bus_rdata = {16'h0, mask_q[c]};
                    if (dec.frc) bus_rdata = {16'h0, frc_q[c]};
                end
            end
        end
    end
endmodule

// File: tb/mpic_ctrl_bench.sv
module mpic_ctrl_bench;
    localparam int NCPU = 4;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0] bus_word = '0;
    logic [15:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] irq_in = '0;
    logic [NCPU-1:0] ack_vld = '0;
    logic [NCPU*4-1:0] ack_num = '0;
    logic [NCPU-1:0] pwr_down = '0;
    logic [NCPU*4-1:0] cpu_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mpic_ctrl #(.NCPU(NCPU)) u_mpic_ctrl (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .ack_vld(ack_vld), .ack_num(ack_num),
        .pwr_down(pwr_down), .cpu_irq(cpu_irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] off, input logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_word = off[7:2]; bus_wdata = d;
        tick();
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] off, input logic [31:0] exp, input string req);
        bus_word = off[7:2];
        #1;
        chk(bus_rdata === exp, req, bus_rdata, exp);
    endtask

    task automatic irq_chk(input int c, input logic [3:0] exp, input string req);
        chk(cpu_irq[c*4 +: 4] === exp, req, 32'(cpu_irq[c*4 +: 4]), 32'(exp));
    endtask

    task automatic pulse(input logic [15:0] v);
        irq_in = v;
        tick();
        irq_in = '0;
    endtask

    task automatic ack(input int c, input logic [3:0] n);
        ack_vld[c] = 1'b1; ack_num[c*4 +: 4] = n;
        tick();
        ack_vld = '0;
    endtask

    task automatic t_reset();
        rd_chk(8'h00, 32'h0, "R10 level");
        rd_chk(8'h04, 32'h0, "R10 pending");
        rd_chk(8'h14, 32'h0, "R10 broadcast");
        rd_chk(8'h40, 32'h0, "R10 mask0");
        rd_chk(8'h84, 32'h0, "R10 force1");
        rd_chk(8'h10, 32'h3800_000E, "R10 R6 status");
        chk(cpu_irq === '0, "R10 outputs", 32'(cpu_irq), 32'h0);
    endtask

    task automatic t_level();
        wr(8'h00, 16'hFFFF);
        rd_chk(8'h00, 32'h0000_FFFE, "R3 level bit0");
        wr(8'h00, 16'h0000);
    endtask

    task automatic t_prio();
        wr(8'h40, 16'hFFFE);
        pulse(16'h0208);
        tick();
        irq_chk(0, 4'd9, "R2 highest in low tier");
        irq_chk(1, 4'd0, "R1 masked processor");
        rd_chk(8'h04, 32'h0000_0208, "R4 pending set");
        wr(8'h00, 16'h0008);
        tick();
        irq_chk(0, 4'd3, "R2 high tier wins");
        wr(8'h44, 16'h0008);
        tick();
        irq_chk(1, 4'd3, "R1 own mask");
        tick();
        bus_word = 6'h04; #1;
        chk(bus_rdata[3:0] === 4'b1100, "R8 wake by output", 32'(bus_rdata[3:0]), 32'hC);
        wr(8'h0C, 16'hFFFF);
        rd_chk(8'h04, 32'h0, "R9 clear pending");
        rd_chk(8'h0C, 32'h0, "R9 clear reads zero");
        wr(8'h00, 16'h0000);
        wr(8'h44, 16'h0000);
        tick();
        irq_chk(0, 4'd0, "R1 nothing requested");
    endtask

    task automatic t_edge();
        irq_in = 16'h0020;
        tick();
        tick();
        irq_chk(0, 4'd5, "R4 edge request");
        ack(0, 4'd5);
        tick(); tick(); tick();
        rd_chk(8'h04, 32'h0, "R4 held line sets once");
        irq_chk(0, 4'd0, "R4 no repeat");
        irq_in = '0;
        tick();
    endtask

    task automatic t_ack();
        wr(8'h80, 16'h0080);
        pulse(16'h0080);
        rd_chk(8'h04, 32'h0000_0080, "R5 pending before ack");
        rd_chk(8'h08, 32'h0000_0080, "R11 force0 alias");
        ack(0, 4'd7);
        rd_chk(8'h80, 32'h0, "R5 force cleared first");
        rd_chk(8'h04, 32'h0000_0080, "R5 pending kept");
        ack(0, 4'd7);
        rd_chk(8'h04, 32'h0, "R5 pending cleared second");
    endtask

    task automatic t_bcast();
        wr(8'h14, 16'h0040);
        pulse(16'h0040);
        for (int c = 0; c < NCPU; c++)
            rd_chk(8'(8'h80 + 4*c), 32'h0000_0040, "R4 broadcast force");
        rd_chk(8'h04, 32'h0, "R4 broadcast skips pending");
        ack(2, 4'd6);
        rd_chk(8'h88, 32'h0, "R5 own force only");
        rd_chk(8'h80, 32'h0000_0040, "R5 other force kept");
        for (int c = 0; c < NCPU; c++) wr(8'(8'h80 + 4*c), 16'h0);
        wr(8'h14, 16'h0);
    endtask

    task automatic t_status();
        pwr_down[1] = 1'b1;
        tick();
        pwr_down = '0;
        rd_chk(8'h10, 32'h3800_000E, "R8 power-down");
        wr(8'h10, 16'h0000);
        rd_chk(8'h10, 32'h3800_000E, "R7 zero write no effect");
        wr(8'h10, 16'h0008);
        rd_chk(8'h10, 32'h3800_0006, "R7 wake by write");
    endtask

    task automatic t_map();
        wr(8'h50, 16'hFFFF);
        rd_chk(8'h50, 32'h0, "R11 absent processor");
        wr(8'h4C, 16'h1235);
        rd_chk(8'h4C, 32'h0000_1234, "R11 R3 mask3");
        rd_chk(8'hC0, 32'h0, "R11 upper block");
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_level();
        t_prio();
        t_edge();
        t_ack();
        t_bcast();
        t_status();
        t_map();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule